// File: doc/BRIEF.md
# SPI flash command bridge

This block connects three word-wide registers to a single-bit SPI flash bus. A write to the command register opens a flash transaction. The transaction sends an opcode and, for opcodes that carry one, a 24-bit byte address. The transaction then stays open: chip-select remains low, and each later access to the data register moves one more word over the bus in the same chip-select window. A data-register read clocks in a word, or the status byte while a status poll is open. A data-register write clocks a word out. Writing an all-zero command closes the window.

A word written to the data register while no transaction is open is held. It goes out automatically right after the header of the next page-program command, so host software can stage the first word of a page before issuing the program opcode. The control register picks the SCK rate and holds a bit that returns the engine to idle.

The engine uses six named states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Chip-select high. |
| `ST_HDR` | Shifting the opcode and address. |
| `ST_OPEN` | Chip-select low, waiting for a register access. |
| `ST_XFER` | Shifting a data word or a status byte. |
| `ST_RDONE` | Read result presented for one cycle. |
| `ST_GAP` | Chip-select held high for one SCK period before the engine returns to idle or starts a queued command. |

Transitions:

- IDLE→HDR on a non-zero command.
- HDR→XFER when a program header ends and a word is staged.
- HDR→OPEN otherwise.
- OPEN→XFER on any data access.
- XFER→RDONE after a read.
- XFER→OPEN after a write.
- RDONE→OPEN.
- OPEN→GAP on any command write.
- GAP→HDR if that command was non-zero.
- GAP→IDLE otherwise.
- Any state→IDLE on the reset bit.

Top module: `spi_flash_bridge`

## Requirements
- R1: After reset, chip-select is high, SCK is low, the interface is ready and the control register reads 0.
- R2: The command word carries the opcode in bits 31:24 and the address in bits 23:0. Opcodes 0x02, 0x03, 0x20, 0x52 and 0xD8 send the opcode byte and then three address bytes, most significant byte first.
- R3: Any other non-zero opcode sends only its opcode byte, and chip-select stays low afterwards.
- R4: Writing an all-zero command while a transaction is open raises chip-select.
- R5: After opcode 0x03, each data-register read returns the next four bytes from consecutive addresses, with the lowest-addressed byte in bits 7:0. Chip-select does not rise between reads.
- R6: After opcode 0x05, each data-register read clocks 8 bits and returns the current status byte in bits 7:0 with the upper bits zero. Repeated reads poll within one window.
- R7: A data-register write made with no transaction open is staged. It is sent right after the header of the next 0x02 command. Later data writes each send 32 bits, bits 7:0 first, and every byte goes MSB first.
- R8: A data-register read holds reg_ready low until its word has been clocked in.
- R9: A non-zero command written while a transaction is open first raises chip-select for at least one SCK period, then sends the new command.
- R10: Writing control bit 0 as 1 raises chip-select and stops SCK on the next cycle, and drops any staged word.
- R11: Control bits 2:1 select the SCK half period: 0 gives 4 clocks, 1 gives 2 clocks, and 2 or 3 gives 1 clock (full speed). The field reads back in the same bits.
- R12: SPI mode 0 holds: SCK is low whenever chip-select is high, and MOSI does not change while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 control |
| reg_wr | input | 1 | Write request, held until reg_ready |
| reg_rd | input | 1 | Read request, held until reg_ready |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_ready is high |
| reg_ready | output | 1 | Access completes on a clock edge where this is high |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
A header of n bits finishes 2·h·n clocks after its command is accepted, where h is the half period. A data read becomes valid about 2·h·32 clocks after the request, or 2·h·8 clocks in status mode, and the chip-select gap lasts 2·h clocks. The bench never samples at a predicted cycle for register results. Its access task holds each request and samples reg_rdata half a clock after reg_ready rises, and the number of stalled cycles itself is checked against the 32-bit shift time. Bus-level results are taken from a behavioural flash model that collects MOSI bytes on SCK rising edges. A per-clock monitor checks the mode-0 rules and records SCK high time and chip-select gap length.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_OPEN, ST_XFER, ST_RDONE, ST_GAP
    } bridge_state_e;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTL  = 2'd2;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_ER4K  = 8'h20;
    localparam logic [7:0] OP_ER32K = 8'h52;
    localparam logic [7:0] OP_ER64K = 8'hD8;

    function automatic logic op_has_addr(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_READ) || (op == OP_ER4K) ||
               (op == OP_ER32K) || (op == OP_ER64K);
    endfunction

    // lowest byte of a register word travels first on the wire
    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/sfb_tick_gen.sv
module sfb_tick_gen #(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        unique case (rate)
            2'd0:    limit = CNT_W'(3);
            2'd1:    limit = CNT_W'(1);
            default: limit = '0;
        endcase
    end

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // slowest rate: two ticks are never adjacent
    assert_slow_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && rate == 2'd0 && $past(rate) == 2'd0 && $past(tick)) |-> !tick);
endmodule

// File: rtl/sfb_shifter.sv
module sfb_shifter #(
    parameter int W    = 32,
    parameter int NB_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            start,
    input  logic [W-1:0]    load,
    input  logic [NB_W-1:0] nbits,
    input  logic            tick,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    rx
);
    logic [W-1:0]    sh_q, rx_q;
    logic [NB_W-1:0] left_q;
    logic            sck_q, busy_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_q   <= '0;
            left_q <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                sck_q  <= 1'b0;
            end else if (start) begin
                sh_q   <= load;
                rx_q   <= '0;
                left_q <= nbits;
                busy_q <= 1'b1;
                sck_q  <= 1'b0;
            end else if (busy_q && tick) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[W-2:0], miso};
                end else begin
                    sck_q  <= 1'b0;
                    sh_q   <= {sh_q[W-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                    if (left_q == NB_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = sh_q[W-1];
    assign busy = busy_q;
    assign done = done_q;
    assign rx   = rx_q;

    assert_mosi_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(sh_q[W-1]));
endmodule

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge
    import sfb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OP_W   = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              reg_ready,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int NB_W = $clog2(WORD_W + 1);

    bridge_state_e     state_q, state_d;
    logic [WORD_W-1:0] cmd_q, cmd_d, pend_q, pend_d, rword_q;
    logic              pend_v_q, pend_v_d, cmd_pend_q, cmd_pend_d;
    logic              rd_mode_q, rd_mode_d, gap_q, gap_d;
    logic [1:0]        rate_q;

    logic              sh_start, sh_busy, sh_done, tick;
    logic [WORD_W-1:0] sh_load, sh_rx;
    logic [NB_W-1:0]   sh_nbits;

    logic acc, cmd_wr, data_wr, data_req, ctl_wr, ctl_rst, stat_mode;

    function automatic logic [WORD_W-1:0] hdr_word(input logic [WORD_W-1:0] c);
        return op_has_addr(c[WORD_W-1 -: OP_W]) ? c : {c[WORD_W-1 -: OP_W], {ADDR_W{1'b0}}};
    endfunction

    function automatic logic [NB_W-1:0] hdr_bits(input logic [WORD_W-1:0] c);
        return op_has_addr(c[WORD_W-1 -: OP_W]) ? NB_W'(WORD_W) : NB_W'(OP_W);
    endfunction

    assign acc       = reg_ready && (reg_wr || reg_rd);
    assign cmd_wr    = acc && reg_wr && (reg_sel == SEL_CMD);
    assign data_wr   = acc && reg_wr && (reg_sel == SEL_DATA);
    assign data_req  = reg_rd && (reg_sel == SEL_DATA);
    assign ctl_wr    = acc && reg_wr && (reg_sel == SEL_CTL);
    assign ctl_rst   = ctl_wr && reg_wdata[0];
    assign stat_mode = (cmd_q[WORD_W-1 -: OP_W] == OP_STAT);

    sfb_tick_gen #(.CNT_W(2)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sh_busy || (state_q == ST_GAP)),
        .rate (rate_q),
        .tick (tick)
    );

    sfb_shifter #(.W(WORD_W), .NB_W(NB_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .abort(ctl_rst),
        .start(sh_start),
        .load (sh_load),
        .nbits(sh_nbits),
        .tick (tick),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .busy (sh_busy),
        .done (sh_done),
        .rx   (sh_rx)
    );

    // next-state and shifter control
    always_comb begin
        state_d    = state_q;
        cmd_d      = cmd_q;
        pend_d     = pend_q;
        pend_v_d   = pend_v_q;
        cmd_pend_d = cmd_pend_q;
        rd_mode_d  = rd_mode_q;
        gap_d      = gap_q;
        sh_start   = 1'b0;
        sh_load    = '0;
        sh_nbits   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (data_wr) begin
                    pend_d   = reg_wdata;
                    pend_v_d = 1'b1;
                end
                if (cmd_wr && reg_wdata != '0) begin
                    cmd_d    = reg_wdata;
                    sh_start = 1'b1;
                    sh_load  = hdr_word(reg_wdata);
                    sh_nbits = hdr_bits(reg_wdata);
                    state_d  = ST_HDR;
                end
            end
            ST_HDR: begin
                if (sh_done) begin
                    if (cmd_q[WORD_W-1 -: OP_W] == OP_PROG && pend_v_q) begin
                        sh_start  = 1'b1;
                        sh_load   = swap_bytes(pend_q);
                        sh_nbits  = NB_W'(WORD_W);
                        pend_v_d  = 1'b0;
                        rd_mode_d = 1'b0;
                        state_d   = ST_XFER;
                    end else begin
                        state_d = ST_OPEN;
                    end
                end
            end
            ST_OPEN: begin
                if (cmd_wr) begin
                    gap_d      = 1'b0;
                    cmd_pend_d = (reg_wdata != '0);
                    if (reg_wdata != '0) cmd_d = reg_wdata;
                    state_d    = ST_GAP;
                end else if (data_wr) begin
                    sh_start  = 1'b1;
                    sh_load   = swap_bytes(reg_wdata);
                    sh_nbits  = NB_W'(WORD_W);
                    rd_mode_d = 1'b0;
                    state_d   = ST_XFER;
                end else if (data_req) begin
                    sh_start  = 1'b1;
                    sh_nbits  = stat_mode ? NB_W'(8) : NB_W'(WORD_W);
                    rd_mode_d = 1'b1;
                    state_d   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (sh_done) state_d = rd_mode_q ? ST_RDONE : ST_OPEN;
            end
            ST_RDONE: state_d = ST_OPEN;
            ST_GAP: begin
                if (tick) begin
                    gap_d = 1'b1;
                    if (gap_q) begin
                        if (cmd_pend_q) begin
                            sh_start = 1'b1;
                            sh_load  = hdr_word(cmd_q);
                            sh_nbits = hdr_bits(cmd_q);
                            state_d  = ST_HDR;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (ctl_rst) begin
            state_d    = ST_IDLE;
            pend_v_d   = 1'b0;
            cmd_pend_d = 1'b0;
            sh_start   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cmd_q      <= '0;
            pend_q     <= '0;
            pend_v_q   <= 1'b0;
            cmd_pend_q <= 1'b0;
            rd_mode_q  <= 1'b0;
            gap_q      <= 1'b0;
            rate_q     <= 2'd0;
            rword_q    <= '0;
        end else begin
            state_q    <= state_d;
            cmd_q      <= cmd_d;
            pend_q     <= pend_d;
            pend_v_q   <= pend_v_d;
            cmd_pend_q <= cmd_pend_d;
            rd_mode_q  <= rd_mode_d;
            gap_q      <= gap_d;
            if (ctl_wr) rate_q <= reg_wdata[2:1];
            if (state_q == ST_XFER && sh_done && rd_mode_q)
                rword_q <= stat_mode ? {{(WORD_W-8){1'b0}}, sh_rx[7:0]} : swap_bytes(sh_rx);
        end
    end

    // outputs
    always_comb begin
        spi_cs_n = (state_q == ST_IDLE) || (state_q == ST_GAP);
        unique case (state_q)
            ST_IDLE, ST_RDONE: reg_ready = 1'b1;
            ST_OPEN:           reg_ready = !data_req;
            default:           reg_ready = 1'b0;
        endcase
        if (reg_sel == SEL_CTL) reg_ready = 1'b1;
        unique case (reg_sel)
            SEL_CMD:  reg_rdata = cmd_q;
            SEL_DATA: reg_rdata = (state_q == ST_RDONE) ? rword_q : '0;
            SEL_CTL:  reg_rdata = {{(WORD_W-3){1'b0}}, rate_q, 1'b0};
            default:  reg_rdata = '0;
        endcase
    end

    assert_idle_sck_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_nop_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && cmd_wr && reg_wdata == '0) |=> spi_cs_n);
    assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_cs_n) && state_q == ST_GAP) |=> spi_cs_n);
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> (state_q == ST_IDLE && !spi_sck));
    assert_read_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && reg_ready && state_q != ST_IDLE) |-> (state_q == ST_RDONE));
    assert_prog_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && sh_done && cmd_q[WORD_W-1 -: OP_W] == OP_PROG && pend_v_q && !ctl_rst)
        |=> (state_q == ST_XFER && sh_busy));
endmodule

// File: tb/spi_flash_bridge_test.sv
module spi_flash_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd2;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready, spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    spi_flash_bridge uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_tests = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // behavioural flash model
    logic [7:0]  m_byte = '0, m_op = '0, m_status = '0;
    logic [23:0] m_addr = '0;
    int          m_bits = 0;
    logic [7:0]  m_q[$];

    function automatic logic [7:0] mem_val(input logic [23:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] exp_word(input logic [23:0] a);
        return {mem_val(a + 24'd3), mem_val(a + 24'd2), mem_val(a + 24'd1), mem_val(a)};
    endfunction

    always @(negedge spi_cs_n) begin
        m_bits = 0;
        m_op   = '0;
    end

    always @(posedge spi_sck) begin
        m_byte = {m_byte[6:0], spi_mosi};
        m_bits++;
        if (m_bits % 8 == 0) begin
            m_q.push_back(m_byte);
            if (m_bits == 8) m_op = m_byte;
            else if (m_bits <= 32) m_addr = {m_addr[15:0], m_byte};
        end
    end

    always @* begin
        int idx;
        logic [7:0] b;
        spi_miso = 1'b0;
        if (m_op == 8'h03 && m_bits >= 32) begin
            idx = m_bits - 32;
            b = mem_val(m_addr + 24'(idx / 8));
            spi_miso = b[7 - (idx % 8)];
        end else if (m_op == 8'h05 && m_bits >= 8) begin
            idx = m_bits - 8;
            spi_miso = m_status[7 - (idx % 8)];
        end
    end

    // per-clock monitor of the bus rules and timing
    int mon_err = 0, hi_len = 0, last_hi = 0, cs_hi_len = 0, last_gap = 0, cs_rises = 0;
    logic prev_sck = 0, prev_mosi = 0, prev_cs = 1;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n && spi_sck) mon_err++;
        if (spi_sck && prev_sck && spi_mosi !== prev_mosi) mon_err++;
        if (spi_sck) hi_len++;
        else if (hi_len != 0) begin last_hi = hi_len; hi_len = 0; end
        if (spi_cs_n) cs_hi_len++;
        else if (cs_hi_len != 0) begin last_gap = cs_hi_len; cs_hi_len = 0; end
        if (spi_cs_n && !prev_cs) cs_rises++;
        prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
    end

    task automatic acc(input logic [1:0] s, input logic w, input logic [31:0] d,
                       output logic [31:0] q, output int nwait);
        @(negedge clk);
        reg_sel = s; reg_wr = w; reg_rd = !w; reg_wdata = d;
        nwait = 0;
        #1;
        while (!reg_ready) begin
            nwait++;
            @(negedge clk);
            #1;
        end
        q = reg_rdata;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        logic [31:0] q; int n;
        acc(s, 1'b1, d, q, n);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] q;
        int nw, rises;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
        check("R1 sck", {31'b0, spi_sck}, 32'd0);
        check("R1 ready", {31'b0, reg_ready}, 32'd1);
        acc(2'd2, 1'b0, '0, q, nw);
        check("R1 ctl", q, 32'd0);

        // R3: opcode-only command
        m_q.delete();
        wr(2'd0, 32'h9000_0000);
        waitc(200);
        check("R3 bytes", m_q.size(), 1);
        check("R3 opcode", {24'b0, m_q[0]}, 32'h90);
        check("R3 cs open", {31'b0, spi_cs_n}, 32'd0);
        wr(2'd0, 32'h0);
        waitc(20);
        check("R4 nop closes", {31'b0, spi_cs_n}, 32'd1);

        // R2: addressed erase
        m_q.delete();
        wr(2'd0, 32'h2000_1000);
        waitc(400);
        check("R2 count", m_q.size(), 4);
        check("R2 hdr", {m_q[0], m_q[1], m_q[2], m_q[3]}, 32'h2000_1000);
        check("R11 rate0 half", last_hi, 4);
        wr(2'd0, 32'h0);
        waitc(20);

        // R5/R8: streaming read
        wr(2'd0, 32'h0300_0100);
        rises = cs_rises;
        acc(2'd1, 1'b0, '0, q, nw);
        check("R5 word0", q, exp_word(24'h000100));
        check("R8 stall", {31'b0, nw >= 256}, 32'd1);
        acc(2'd1, 1'b0, '0, q, nw);
        check("R5 word1", q, exp_word(24'h000104));
        check("R5 cs held", cs_rises, rises);
        wr(2'd0, 32'h0);
        waitc(20);

        // R6: status polling
        m_status = 8'h01;
        wr(2'd0, 32'h0500_0000);
        rises = cs_rises;
        acc(2'd1, 1'b0, '0, q, nw);
        check("R6 busy", q, 32'h1);
        m_status = 8'h00;
        acc(2'd1, 1'b0, '0, q, nw);
        check("R6 ready", q, 32'h0);
        check("R6 one window", cs_rises, rises);
        wr(2'd0, 32'h0);
        waitc(20);

        // R11: full speed
        wr(2'd2, 32'h4);
        acc(2'd2, 1'b0, '0, q, nw);
        check("R11 readback", q, 32'h4);

        // R7: staged first word for program
        wr(2'd1, 32'h4433_2211);
        m_q.delete();
        wr(2'd0, 32'h0200_0200);
        wr(2'd1, 32'h8877_6655);
        wr(2'd0, 32'h0);
        waitc(20);
        check("R7 count", m_q.size(), 12);
        check("R7 hdr", {m_q[0], m_q[1], m_q[2], m_q[3]}, 32'h0200_0200);
        check("R7 staged", {m_q[4], m_q[5], m_q[6], m_q[7]}, 32'h1122_3344);
        check("R7 next", {m_q[8], m_q[9], m_q[10], m_q[11]}, 32'h5566_7788);
        check("R11 full half", last_hi, 1);

        // R9: command while open
        wr(2'd0, 32'h0300_0000);
        waitc(100);
        m_q.delete();
        wr(2'd0, 32'h0600_0000);
        waitc(100);
        check("R9 gap", {31'b0, last_gap >= 2}, 32'd1);
        check("R9 count", m_q.size(), 1);
        check("R9 opcode", {24'b0, m_q[0]}, 32'h06);
        check("R9 open", {31'b0, spi_cs_n}, 32'd0);
        wr(2'd0, 32'h0);
        waitc(20);

        // R10: abort mid-header drops staged word
        wr(2'd1, 32'hDEAD_BEEF);
        wr(2'd0, 32'h0500_0000);
        waitc(5);
        wr(2'd2, 32'h5);
        check("R10 cs", {31'b0, spi_cs_n}, 32'd1);
        check("R10 sck", {31'b0, spi_sck}, 32'd0);
        waitc(5);
        m_q.delete();
        wr(2'd0, 32'h0200_0300);
        waitc(150);
        check("R10 no staged", m_q.size(), 4);
        wr(2'd0, 32'h0);
        waitc(20);

        check("R12 monitor", mon_err, 0);
        done_flag = 1;
        finish_run();
    end
endmodule